// File: doc/BRIEF.md
# Sampling Phase Tuning Controller

This block searches for a good receive sampling delay on a high-speed SD/eMMC host bus. Once started, it sweeps a delay code upward in coarse steps. At every step it programs the delay line, asks the command path to issue a tuning-block read, and compares each received data word with a reference pattern built into the block. The pattern depends on the bus width. A trial passes only when every word matches. The block tracks the longest run of consecutive passing trials and finally programs the delay code at the centre of that run.

Before sweeping, the block checks whether tuning is needed at all. Slow bus clocks skip the sweep. Mid-range clocks sweep only when a capability input allows it. Unsupported bus widths, a sweep with no passing trial, and a missing tuning response all end the run with an error code, and the host is left in fixed sampling mode. Every run ends with a one-cycle done pulse.

The controller is a single state machine with these states. IDLE waits for start and latches the inputs. CHECK validates the width and decides between skipping and tuning. PROG pulses the delay load with the trial code. ISSUE holds the command request until it is acknowledged. COLLECT counts and compares the received words. SCORE updates the window tracker and either steps the code (back to PROG) or ends the sweep (to APPLY). APPLY picks the centre code or flags that no trial passed. DONE pulses done and returns to IDLE. CHECK goes straight to DONE on a bad width or a skip, and COLLECT goes straight to DONE on a timeout.

Top module: `phase_tuner`

## Requirements
- R1: After reset, done_o, err_o, cmd_req_o and dly_load_o are low, fixed_mode_o is high, and err_code_o and final_code_o are zero.
- R2: The bus width code is 1 for a 4-bit bus (16 words per trial) and 2 for an 8-bit bus (32 words per trial). Codes 0 and 3 end the run with err_code_o = 1, fixed_mode_o high, final_code_o zero, and no command issued.
- R3: Tuning is skipped when the bus clock is at most 52 MHz, and also when it is at most 104 MHz with the capability input low. A skipped run ends with done, err_code_o = 0, fixed_mode_o high and no command. Otherwise it sweeps, and fixed_mode_o stays low while commands are issued.
- R4: The sweep loads codes 0, 4, 8, … while the code is below 127, which gives 32 trials. Each load is followed by one command request, held until it is acknowledged and carrying the opcode latched at start.
- R5: Received word k of a trial must equal the seed XOR the index byte k repeated in all four bytes. The seed is 0x0F1E2D3C for a 4-bit bus and 0xF0E1D2C3 for an 8-bit bus. Only words with rx_valid_i high are counted. A mismatch in any word, the last one included, fails the trial.
- R6: The longest run of consecutive passing trials is kept. A later run replaces it only if it is strictly longer, so on a tie the earlier run wins.
- R7: On success, final_code_o = 4 × (best start trial + best length / 2), with integer halving. Done comes with dly_load_o carrying that code, fixed_mode_o low and err_code_o = 0.
- R8: If no trial passes, the run ends with err_code_o = 2, fixed_mode_o high and no delay load on done.
- R9: rx_timeout_i during a trial ends the run at once with err_code_o = 3 and fixed_mode_o high. No further command is issued.
- R10: done_o is a one-cycle pulse, and err_o is high with it exactly when err_code_o is nonzero. start_i and input changes during a run have no effect on that run.
- R11: Each start clears the window history, so a run's result depends only on that run's trials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only in IDLE |
| opcode_i | input | 6 | Tuning command opcode |
| bus_width_i | input | 2 | Bus width code (1 = 4-bit, 2 = 8-bit) |
| clk_mhz_i | input | 10 | Bus clock frequency in MHz |
| sdr50_tune_cap_i | input | 1 | Allows tuning in the 52 to 104 MHz range |
| cmd_req_o | output | 1 | Tuning read request to the command path |
| cmd_opcode_o | output | 6 | Opcode for the request |
| cmd_ack_i | input | 1 | Command path accepted the request |
| rx_valid_i | input | 1 | Received word strobe |
| rx_word_i | input | 32 | Received tuning data word |
| rx_timeout_i | input | 1 | Tuning response missed its window |
| dly_load_o | output | 1 | Load the delay line with dly_code_o |
| dly_code_o | output | 7 | Delay code to load |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Error flag, valid with done_o |
| err_code_o | output | 2 | 0 none, 1 width, 2 no pass, 3 timeout |
| final_code_o | output | 7 | Chosen delay code |
| fixed_mode_o | output | 1 | High when the host uses fixed sampling |

## Verification
The sweep is driven with pass masks that separate the window rules from one another. A single mid-sweep run checks centring with an even length. Two equal runs check that ties keep the earlier one. An all-pass mask and a mask where only the last trial passes check the two ends of the code range. An empty mask checks the no-pass error. Corrupting only the final word of a failing trial shows whether the last word is compared, and idle gaps with junk data show whether words are counted only on the valid strobe. Frequency and width sweeps around 52 and 104 MHz, a timeout in the middle, a run whose short window follows a long one, and a restart request during a run separate the gating, abort, clearing and input-latching behaviour.

// File: rtl/tune_pkg.sv
package tune_pkg;

    localparam int PAT_W = 32;

    localparam logic [1:0] BUS_X4 = 2'b01;
    localparam logic [1:0] BUS_X8 = 2'b10;

    localparam logic [PAT_W-1:0] SEED_X4 = 32'h0F1E_2D3C;
    localparam logic [PAT_W-1:0] SEED_X8 = 32'hF0E1_D2C3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_PROG,
        S_ISSUE,
        S_COLLECT,
        S_SCORE,
        S_APPLY,
        S_DONE
    } tune_state_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_WIDTH   = 2'd1,
        ERR_NOPASS  = 2'd2,
        ERR_TIMEOUT = 2'd3
    } tune_err_t;

    // Expected word: width seed XOR the index byte copied into every byte lane.
    function automatic logic [PAT_W-1:0] pattern_word(input logic wide, input logic [7:0] k);
        return (wide ? SEED_X8 : SEED_X4) ^ {(PAT_W/8){k}};
    endfunction

endpackage

// File: rtl/tune_ref_rom.sv
module tune_ref_rom
    import tune_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             wide_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [PAT_W-1:0] word_o
);

    logic [7:0] k;

    generate
        if (IDX_W >= 8) begin : g_trunc
            assign k = idx_i[7:0];
        end else begin : g_ext
            assign k = {{(8-IDX_W){1'b0}}, idx_i};
        end
    endgenerate

    assign word_o = pattern_word(wide_i, k);

endmodule

// File: rtl/tune_trial_cmp.sv
module tune_trial_cmp
    import tune_pkg::*;
#(
    parameter int N4    = 16,
    parameter int N8    = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             wide_i,
    input  logic             beat_i,
    input  logic [PAT_W-1:0] rx_word_i,
    input  logic [PAT_W-1:0] ref_word_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             mism_o,
    output logic             last_o
);

    localparam logic [IDX_W-1:0] LAST_X4 = IDX_W'(N4 - 1);
    localparam logic [IDX_W-1:0] LAST_X8 = IDX_W'(N8 - 1);

    logic [IDX_W-1:0] idx_q;
    logic             mism_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mism_q <= 1'b0;
        end else if (clear_i) begin
            idx_q  <= '0;
            mism_q <= 1'b0;
        end else if (beat_i) begin
            idx_q <= idx_q + IDX_W'(1);
            if (rx_word_i != ref_word_i) begin
                mism_q <= 1'b1;
            end
        end
    end

    assign idx_o  = idx_q;
    assign mism_o = mism_q;
    assign last_o = beat_i && (idx_q == (wide_i ? LAST_X8 : LAST_X4));

endmodule

// File: rtl/tune_window.sv
module tune_window #(
    parameter int IDX_W = 5,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             score_i,
    input  logic             pass_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] best_start_o,
    output logic [LEN_W-1:0] best_len_o
);

    logic [IDX_W-1:0] cur_start_q, best_start_q, run_start;
    logic [LEN_W-1:0] cur_len_q, best_len_q, run_len;
    logic             prev_q;

    always_comb begin
        if (prev_q) begin
            run_start = cur_start_q;
            run_len   = cur_len_q + LEN_W'(1);
        end else begin
            run_start = idx_i;
            run_len   = LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_start_q  <= '0;
            cur_len_q    <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
            prev_q       <= 1'b0;
        end else if (clear_i) begin
            cur_start_q  <= '0;
            cur_len_q    <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
            prev_q       <= 1'b0;
        end else if (score_i) begin
            if (pass_i) begin
                cur_start_q <= run_start;
                cur_len_q   <= run_len;
                prev_q      <= 1'b1;
                if (run_len > best_len_q) begin
                    best_start_q <= run_start;
                    best_len_q   <= run_len;
                end
            end else begin
                prev_q <= 1'b0;
            end
        end
    end

    assign best_start_o = best_start_q;
    assign best_len_o   = best_len_q;

endmodule

// File: rtl/phase_tuner.sv
module phase_tuner
    import tune_pkg::*;
#(
    parameter int CODE_W    = 7,
    parameter int STEP      = 4,
    parameter int OPC_W     = 6,
    parameter int FREQ_W    = 10,
    parameter int SKIP_MHZ  = 52,
    parameter int SDR50_MHZ = 104,
    parameter int N4        = 16,
    parameter int N8        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [1:0]        bus_width_i,
    input  logic [FREQ_W-1:0] clk_mhz_i,
    input  logic              sdr50_tune_cap_i,
    output logic              cmd_req_o,
    output logic [OPC_W-1:0]  cmd_opcode_o,
    input  logic              cmd_ack_i,
    input  logic              rx_valid_i,
    input  logic [PAT_W-1:0]  rx_word_i,
    input  logic              rx_timeout_i,
    output logic              dly_load_o,
    output logic [CODE_W-1:0] dly_code_o,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        err_code_o,
    output logic [CODE_W-1:0] final_code_o,
    output logic              fixed_mode_o
);

    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int NTRIALS  = (CODE_MAX + STEP - 1) / STEP;
    localparam int TRIAL_W  = (NTRIALS > 1) ? $clog2(NTRIALS) : 1;
    localparam int LEN_W    = $clog2(NTRIALS + 1);
    localparam int WIDX_W   = $clog2(N8);

    tune_state_t state_q, state_d;
    tune_err_t   err_q;

    logic [OPC_W-1:0]  opc_q;
    logic              wide_q, bw_ok_q, cap_q;
    logic [FREQ_W-1:0] mhz_q;
    logic [CODE_W-1:0] code_q, final_q;
    logic [TRIAL_W-1:0] trial_q;
    logic              fixed_q;

    logic              need_tune, more, beat, last_beat, mism;
    logic [CODE_W:0]   code_nx;
    logic [WIDX_W-1:0] widx;
    logic [PAT_W-1:0]  ref_word;
    logic [TRIAL_W-1:0] best_start;
    logic [LEN_W-1:0]  best_len;
    logic [LEN_W:0]    mid_idx;
    logic [CODE_W-1:0] final_c;
    logic              win_clear;

    assign need_tune = (mhz_q > FREQ_W'(SDR50_MHZ)) ||
                       ((mhz_q > FREQ_W'(SKIP_MHZ)) && cap_q);
    assign code_nx   = {1'b0, code_q} + (CODE_W+1)'(STEP);
    assign more      = code_nx < (CODE_W+1)'(CODE_MAX);
    assign beat      = (state_q == S_COLLECT) && rx_valid_i && !rx_timeout_i;
    assign win_clear = (state_q == S_IDLE) && start_i;
    assign mid_idx   = (LEN_W+1)'(best_start) + (LEN_W+1)'(best_len >> 1);
    assign final_c   = CODE_W'(mid_idx * STEP);

    tune_ref_rom #(.IDX_W(WIDX_W)) u_rom (
        .wide_i (wide_q),
        .idx_i  (widx),
        .word_o (ref_word)
    );

    tune_trial_cmp #(.N4(N4), .N8(N8), .IDX_W(WIDX_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (state_q == S_PROG),
        .wide_i     (wide_q),
        .beat_i     (beat),
        .rx_word_i  (rx_word_i),
        .ref_word_i (ref_word),
        .idx_o      (widx),
        .mism_o     (mism),
        .last_o     (last_beat)
    );

    tune_window #(.IDX_W(TRIAL_W), .LEN_W(LEN_W)) u_win (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (win_clear),
        .score_i      (state_q == S_SCORE),
        .pass_i       (!mism),
        .idx_i        (trial_q),
        .best_start_o (best_start),
        .best_len_o   (best_len)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_CHECK;
            S_CHECK:   state_d = (!bw_ok_q || !need_tune) ? S_DONE : S_PROG;
            S_PROG:    state_d = S_ISSUE;
            S_ISSUE:   if (cmd_ack_i) state_d = S_COLLECT;
            S_COLLECT: begin
                if (rx_timeout_i)   state_d = S_DONE;
                else if (last_beat) state_d = S_SCORE;
            end
            S_SCORE:   state_d = more ? S_PROG : S_APPLY;
            S_APPLY:   state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // run datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q   <= '0;
            wide_q  <= 1'b0;
            bw_ok_q <= 1'b0;
            cap_q   <= 1'b0;
            mhz_q   <= '0;
            code_q  <= '0;
            trial_q <= '0;
            final_q <= '0;
            err_q   <= ERR_NONE;
            fixed_q <= 1'b1;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    opc_q   <= opcode_i;
                    wide_q  <= (bus_width_i == BUS_X8);
                    bw_ok_q <= (bus_width_i == BUS_X8) || (bus_width_i == BUS_X4);
                    cap_q   <= sdr50_tune_cap_i;
                    mhz_q   <= clk_mhz_i;
                end
                S_CHECK: begin
                    final_q <= '0;
                    code_q  <= '0;
                    trial_q <= '0;
                    if (!bw_ok_q) begin
                        err_q   <= ERR_WIDTH;
                        fixed_q <= 1'b1;
                    end else if (!need_tune) begin
                        err_q   <= ERR_NONE;
                        fixed_q <= 1'b1;
                    end else begin
                        err_q   <= ERR_NONE;
                        fixed_q <= 1'b0;
                    end
                end
                S_COLLECT: if (rx_timeout_i) begin
                    err_q   <= ERR_TIMEOUT;
                    fixed_q <= 1'b1;
                    final_q <= '0;
                end
                S_SCORE: if (more) begin
                    code_q  <= code_nx[CODE_W-1:0];
                    trial_q <= trial_q + TRIAL_W'(1);
                end
                S_APPLY: begin
                    if (best_len == '0) begin
                        err_q   <= ERR_NOPASS;
                        fixed_q <= 1'b1;
                        final_q <= '0;
                    end else begin
                        err_q   <= ERR_NONE;
                        fixed_q <= 1'b0;
                        final_q <= final_c;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_req_o    = (state_q == S_ISSUE);
        cmd_opcode_o = opc_q;
        done_o       = (state_q == S_DONE);
        err_o        = (state_q == S_DONE) && (err_q != ERR_NONE);
        dly_load_o   = (state_q == S_PROG) ||
                       ((state_q == S_DONE) && (err_q == ERR_NONE) && !fixed_q);
        dly_code_o   = (state_q == S_DONE) ? final_q : code_q;
        err_code_o   = err_q;
        final_code_o = final_q;
        fixed_mode_o = fixed_q;
    end

endmodule

// File: rtl/tune_chk.sv
module tune_chk #(
    parameter int CODE_W = 7,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_req_o,
    input logic              cmd_ack_i,
    input logic              dly_load_o,
    input logic [CODE_W-1:0] dly_code_o,
    input logic              done_o,
    input logic              err_o,
    input logic              fixed_mode_o
);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_o && !cmd_ack_i) |=> cmd_req_o);

    // R4
    code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_load_o |-> ((int'(dly_code_o) % STEP) == 0));

    // R4
    req_load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_req_o, dly_load_o}));

    // R3
    tune_not_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_o |-> !fixed_mode_o);

    // R8
    err_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> fixed_mode_o);

endmodule

bind phase_tuner tune_chk #(.CODE_W(CODE_W), .STEP(STEP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_req_o    (cmd_req_o),
    .cmd_ack_i    (cmd_ack_i),
    .dly_load_o   (dly_load_o),
    .dly_code_o   (dly_code_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .fixed_mode_o (fixed_mode_o)
);

// File: tb/sim_phase_tuner.sv
`timescale 1ns/1ps
module sim_phase_tuner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  opcode_i = '0;
    logic [1:0]  bus_width_i = '0;
    logic [9:0]  clk_mhz_i = '0;
    logic        sdr50_tune_cap_i = 1'b0;
    logic        cmd_req_o;
    logic [5:0]  cmd_opcode_o;
    logic        cmd_ack_i;
    logic        rx_valid_i;
    logic [31:0] rx_word_i;
    logic        rx_timeout_i;
    logic        dly_load_o;
    logic [6:0]  dly_code_o;
    logic        done_o, err_o, fixed_mode_o;
    logic [1:0]  err_code_o;
    logic [6:0]  final_code_o;

    always #2.5 clk = ~clk;

    phase_tuner u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .bus_width_i(bus_width_i), .clk_mhz_i(clk_mhz_i),
        .sdr50_tune_cap_i(sdr50_tune_cap_i), .cmd_req_o(cmd_req_o),
        .cmd_opcode_o(cmd_opcode_o), .cmd_ack_i(cmd_ack_i),
        .rx_valid_i(rx_valid_i), .rx_word_i(rx_word_i),
        .rx_timeout_i(rx_timeout_i), .dly_load_o(dly_load_o),
        .dly_code_o(dly_code_o), .done_o(done_o), .err_o(err_o),
        .err_code_o(err_code_o), .final_code_o(final_code_o),
        .fixed_mode_o(fixed_mode_o)
    );

    int checks = 0;
    int errors = 0;
    bit over = 0;

    // run configuration shared with the card model
    logic [31:0] r_mask = '0;
    int          r_to = -1;
    int          r_cmode = 0;
    bit          r_wide = 0;
    int          r_opc = 0;
    bit          exp_tune = 0;
    int          exp_code = 0;
    int          cmd_cnt = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input bit wide, input int k);
        logic [7:0] b;
        b = 8'(k);
        return (wide ? 32'hF0E1_D2C3 : 32'h0F1E_2D3C) ^ {b, b, b, b};
    endfunction

    // card / command-path model, checked on every clock
    initial begin
        int cur;
        cur = 0;
        cmd_ack_i = 1'b0;
        rx_valid_i = 1'b0;
        rx_word_i = '0;
        rx_timeout_i = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (dly_load_o && !done_o) begin
                chk("R4 sweep code", int'(dly_code_o), exp_code);
                cur = int'(dly_code_o) / 4;
                exp_code += 4;
            end
            if (cmd_req_o) begin
                cmd_cnt++;
                if (!exp_tune) chk("R3 command while tuning skipped", 1, 0);
                chk("R4 opcode", int'(cmd_opcode_o), r_opc);
                if (cur % 2 == 1) @(negedge clk);
                cmd_ack_i = 1'b1;
                @(negedge clk);
                cmd_ack_i = 1'b0;
                if (cur == r_to) begin
                    rx_timeout_i = 1'b1;
                    @(negedge clk);
                    rx_timeout_i = 1'b0;
                end else begin
                    int nw, ci;
                    bit bad;
                    nw  = r_wide ? 32 : 16;
                    bad = !r_mask[cur];
                    ci  = (r_cmode != 0) ? nw - 1 : cur % nw;
                    for (int w = 0; w < nw; w++) begin
                        if (w % 3 == 2) begin
                            rx_valid_i = 1'b0;
                            rx_word_i  = 32'hDEAD_0000 + 32'(w);
                            @(negedge clk);
                        end
                        rx_valid_i = 1'b1;
                        rx_word_i  = pat(r_wide, w) ^
                                     ((bad && w == ci) ? (32'h1 << (cur % 32)) : 32'h0);
                        @(negedge clk);
                    end
                    rx_valid_i = 1'b0;
                end
            end
        end
    end

    task automatic run(input string tag, input logic [1:0] bw, input int mhz,
                       input bit cap, input logic [31:0] mask, input int to,
                       input int cmode, input bit poke);
        bit bw_ok, tune;
        int e_err, e_fixed, e_final, e_load, e_cmds;
        int bs, bl, cs, cl, n;
        bw_ok = (bw == 2'd1) || (bw == 2'd2);
        tune  = bw_ok && (mhz > 104 || (mhz > 52 && cap));
        e_load = 0;
        e_final = 0;
        if (!bw_ok) begin
            e_err = 1; e_fixed = 1; e_cmds = 0;
        end else if (!tune) begin
            e_err = 0; e_fixed = 1; e_cmds = 0;
        end else if (to >= 0 && to < 32) begin
            e_err = 3; e_fixed = 1; e_cmds = to + 1;
        end else begin
            bs = 0; bl = 0; cs = 0; cl = 0;
            for (int t = 0; t < 32; t++) begin
                if (mask[t]) begin
                    if (cl == 0) cs = t;
                    cl++;
                    if (cl > bl) begin bl = cl; bs = cs; end
                end else begin
                    cl = 0;
                end
            end
            e_cmds = 32;
            if (bl == 0) begin
                e_err = 2; e_fixed = 1;
            end else begin
                e_err = 0; e_fixed = 0; e_load = 1;
                e_final = 4 * (bs + bl / 2);
            end
        end
        r_mask = mask; r_to = to; r_cmode = cmode;
        r_wide = (bw == 2'd2); r_opc = 19 + (mhz % 7);
        exp_tune = tune; exp_code = 0; cmd_cnt = 0;

        bus_width_i = bw; clk_mhz_i = 10'(mhz); sdr50_tune_cap_i = cap;
        opcode_i = 6'(r_opc); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 20000) begin
            if (poke && n == 150) begin
                start_i = 1'b1; bus_width_i = 2'd3; clk_mhz_i = 10'd20;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        chk({tag, " done seen (R10)"}, int'(done_o), 1);
        chk({tag, " err_code"}, int'(err_code_o), e_err);
        chk({tag, " err flag (R10)"}, int'(err_o), (e_err != 0) ? 1 : 0);
        chk({tag, " final code"}, int'(final_code_o), e_final);
        chk({tag, " fixed mode"}, int'(fixed_mode_o), e_fixed);
        chk({tag, " delay load on done"}, int'(dly_load_o), e_load);
        if (e_load != 0) chk({tag, " loaded code"}, int'(dly_code_o), e_final);
        @(negedge clk);
        chk({tag, " done one cycle (R10)"}, int'(done_o), 0);
        chk({tag, " command count"}, cmd_cnt, e_cmds);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", int'(done_o), 0);
        chk("R1 err", int'(err_o), 0);
        chk("R1 cmd_req", int'(cmd_req_o), 0);
        chk("R1 dly_load", int'(dly_load_o), 0);
        chk("R1 fixed", int'(fixed_mode_o), 1);
        chk("R1 err_code", int'(err_code_o), 0);
        chk("R1 final", int'(final_code_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run("R2 width code 0", 2'd0, 200, 1'b1, 32'hFFFF_FFFF, -1, 0, 1'b0);
        run("R2 width code 3", 2'd3, 200, 1'b1, 32'hFFFF_FFFF, -1, 0, 1'b0);
        run("R3 50MHz skip", 2'd1, 50, 1'b1, 32'hFFFF_FFFF, -1, 0, 1'b0);
        run("R3 52MHz skip", 2'd2, 52, 1'b1, 32'hFFFF_FFFF, -1, 0, 1'b0);
        run("R3 100MHz no cap", 2'd1, 100, 1'b0, 32'hFFFF_FFFF, -1, 0, 1'b0);
        run("R3 104MHz no cap", 2'd2, 104, 1'b0, 32'hFFFF_FFFF, -1, 0, 1'b0);
        run("R3 104MHz cap tunes", 2'd1, 104, 1'b1, 32'h0000_FF00, -1, 0, 1'b0);
        run("R7 even window 4-bit", 2'd1, 200, 1'b0, 32'h0000_FF00, -1, 0, 1'b0);
        run("R6 tie keeps earlier", 2'd2, 200, 1'b0, 32'h0000_1C1C, -1, 0, 1'b0);
        run("R5 last word corrupt", 2'd2, 150, 1'b0, 32'h00F0_0F00, -1, 1, 1'b0);
        run("R7 all pass", 2'd2, 200, 1'b0, 32'hFFFF_FFFF, -1, 0, 1'b0);
        run("R7 last trial only", 2'd1, 200, 1'b0, 32'h8000_0000, -1, 0, 1'b0);
        run("R8 no pass", 2'd1, 200, 1'b0, 32'h0000_0000, -1, 0, 1'b0);
        run("R9 timeout", 2'd2, 200, 1'b0, 32'hFFFF_FFFF, 5, 0, 1'b0);
        run("R11 short after long", 2'd1, 200, 1'b0, 32'h0000_0018, -1, 0, 1'b0);
        run("R10 start ignored busy", 2'd1, 200, 1'b0, 32'hFFFF_0000, -1, 0, 1'b1);

        over = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!over) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule